// File: doc/BRIEF.md
# Pixel Trace Path Detector

This block watches the column readings of a row-scanned pixel matrix and decides whether a marker trace runs as one unbroken path from the top row to the bottom row of a scan frame. A scan controller presents a row index, a one-cycle sample strobe and the column vector of the active row. The detector keeps only a small amount of path state (the column accepted in the previous row, the row index it came from, the lateral direction chosen so far and a valid bit) and evaluates each sampled row against it. It does not store whole frames.

Three path rules are selectable. The first accepts only the straight diagonal. The second accepts any curve whose pixel moves by at most one column between rows. The third accepts such a curve only if it never changes lateral direction. When the last row of a frame completes a valid path, a sticky detection flag is set. It stays set until the user clear input removes it. While the flag is set, a blink output toggles at a divided rate, so that it can drive a display digit.

Top module: `trace_path_detector`

## Requirements
- R1: After a synchronous active-low reset, `found` and `blink` are both 0.
- R2: `row_idx` and `cols` have no effect on the path state or on `found` in cycles where `sample` is 0.
- R3: A sampled row must have exactly one bit of `cols` set. A row with no bit set, or with two or more bits set, fails the current frame.
- R4: With `mode` = 0 (diagonal), a row passes only if the single set bit of `cols` is at bit position equal to `row_idx`, with bit 0 as the leftmost column.
- R5: With `mode` = 1 (curve), row 0 may have its bit at any column. Each later row passes only if its column differs by -1, 0 or +1 from the column accepted in the previous row.
- R6: With `mode` = 2 or 3 (no zigzag), the R5 adjacency rule applies. A zero offset leaves the direction open. The first nonzero offset fixes the direction, and a later offset of the opposite sign fails the frame.
- R7: A sample of row 0 restarts the path. Each later sampled row must carry the index one above the previously sampled row, or the frame fails.
- R8: `found` rises in the cycle after the sample of row N_ROWS-1 that completes a valid path, and at no other time.
- R9: `found` stays at 1 until `clear` is 1 at a clock edge. When `clear` and a completing sample meet at the same edge, `clear` wins.
- R10: While `found` is 1, `blink` is 0 for the first BLINK_HALF cycles and then toggles every BLINK_HALF cycles. While `found` is 0, `blink` is 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| row_idx | input | $clog2(N_ROWS) | Index of the active row |
| sample | input | 1 | Strobe marking the cycle in which `cols` is evaluated |
| cols | input | N_COLS | Column readings of the active row, bit i = column i |
| mode | input | 2 | Path rule: 0 diagonal, 1 curve, 2 or 3 no zigzag |
| clear | input | 1 | User clear of the detection flag |
| found | output | 1 | Sticky detection flag |
| blink | output | 1 | Divided blink signal, gated by `found` |

## Verification
The properties assume that `row_idx` stays below N_ROWS whenever `sample` is 1. They also assume that `sample` is a single-cycle pulse per row, in the way the scan controller produces it. The stimulus keeps to this. It drives one strobe per row with in-range indices and holds the strobe low for three cycles in between, while it puts unrelated column vectors on the bus. The only out-of-order rows the stimulus produces are deliberate skips and repeats, and these stay inside the index range. This lets the continuity rule be exercised without breaking the assumption.

// File: rtl/trace_pkg.sv
// Shared types for the pixel trace path detector.
// Assumes: nothing beyond the encodings stated in the brief.
package trace_pkg;

    // Path rule selected by the mode input
    typedef enum logic [1:0] {
        MODE_DIAG     = 2'd0,
        MODE_CURVE    = 2'd1,
        MODE_MONO     = 2'd2,
        MODE_MONO_ALT = 2'd3
    } trace_mode_e;

    // Lateral direction committed so far by a no-zigzag path
    typedef enum logic [1:0] {
        LEAN_FREE  = 2'd0,
        LEAN_RIGHT = 2'd1,
        LEAN_LEFT  = 2'd2
    } lean_e;

endpackage

// File: rtl/row_decoder.sv
// Row decoder: reports whether exactly one column bit is set and, if so,
// the index of that bit.
// Assumes: the index output is meaningful only when one_hot is 1.
module row_decoder #(
    parameter int N_COLS = 10,
    localparam int COL_W = $clog2(N_COLS)
) (
    input  logic [N_COLS-1:0] cols,
    output logic              one_hot,
    output logic [COL_W-1:0]  col_idx
);

    // Single-bit test on the column vector
    always_comb begin
        one_hot = $onehot(cols);
    end

    // Index encoder: OR of the positions of all set bits
    always_comb begin
        col_idx = '0;
        for (int i = 0; i < N_COLS; i++) begin
            if (cols[i]) col_idx = col_idx | COL_W'(i);
        end
    end

endmodule

// File: rtl/path_tracker.sv
// Path tracker: holds the state of the path through the current frame and
// judges each sampled row against the selected rule. It raises a one-cycle
// hit when the last row completes a valid path.
// Assumes: row_idx < N_ROWS whenever sample is 1; the decoder outputs
// belong to the same cycle as sample.
module path_tracker
    import trace_pkg::*;
#(
    parameter int N_ROWS = 10,
    parameter int N_COLS = 10,
    localparam int ROW_W = $clog2(N_ROWS),
    localparam int COL_W = $clog2(N_COLS),
    localparam int CMP_W = ((ROW_W > COL_W) ? ROW_W : COL_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [ROW_W-1:0] row_idx,
    input  trace_mode_e      mode,
    input  logic             one_hot,
    input  logic [COL_W-1:0] col_idx,
    output logic             hit
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_ROWS - 1);

    logic             trk_valid;
    logic [COL_W-1:0] last_col;
    logic [ROW_W-1:0] last_row;
    lean_e            lean;

    logic [CMP_W-1:0] c_now, c_last, r_now, r_last;
    logic             row_first, chain_ok, step_up, step_down, step_same;
    logic             adj_ok, mono_ok, rule_ok, row_pass;
    lean_e            lean_nxt;

    // Common-width copies of the row and column values used in the compares
    always_comb begin
        c_now  = CMP_W'(col_idx);
        c_last = CMP_W'(last_col);
        r_now  = CMP_W'(row_idx);
        r_last = CMP_W'(last_row);
    end

    // Column offset from the previously accepted row
    always_comb begin
        step_up   = (c_now == c_last + CMP_W'(1));
        step_down = (c_now + CMP_W'(1) == c_last);
        step_same = (c_now == c_last);
        adj_ok    = step_up | step_down | step_same;
    end

    // Direction rule: an offset opposite to the committed lean is refused
    always_comb begin
        mono_ok = adj_ok
                  && !((lean == LEAN_RIGHT) && step_down)
                  && !((lean == LEAN_LEFT)  && step_up);
    end

    // Row continuity and per-mode judgement of the sampled row
    always_comb begin
        row_first = (row_idx == '0);
        chain_ok  = trk_valid && (r_now == r_last + CMP_W'(1));
        unique case (mode)
            MODE_DIAG:     rule_ok = (c_now == r_now);
            MODE_CURVE:    rule_ok = row_first || adj_ok;
            MODE_MONO,
            MODE_MONO_ALT: rule_ok = row_first || mono_ok;
            default:       rule_ok = 1'b0;
        endcase
        row_pass = one_hot && rule_ok && (row_first || chain_ok);
    end

    // Lean update: row 0 frees it, the first nonzero offset fixes it
    always_comb begin
        lean_nxt = lean;
        if (row_first) begin
            lean_nxt = LEAN_FREE;
        end else if (lean == LEAN_FREE) begin
            if (step_up)        lean_nxt = LEAN_RIGHT;
            else if (step_down) lean_nxt = LEAN_LEFT;
        end
    end

    // Completion: the last row is sampled and it passes
    always_comb begin
        hit = sample && (row_idx == LAST_ROW) && row_pass;
    end

    // Path state register, written only on sample cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_valid <= 1'b0;
            last_col  <= '0;
            last_row  <= '0;
            lean      <= LEAN_FREE;
        end else if (sample) begin
            trk_valid <= row_pass;
            last_col  <= col_idx;
            last_row  <= row_idx;
            lean      <= lean_nxt;
        end
    end

endmodule

// File: rtl/flag_blinker.sv
// Sticky detection flag with clear priority, plus a divided blink phase
// gated by the flag.
// Assumes: BLINK_HALF >= 2.
module flag_blinker #(
    parameter int BLINK_HALF = 8,
    localparam int CNT_W = $clog2(BLINK_HALF)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clear,
    output logic found,
    output logic blink
);

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BLINK_HALF - 1);

    logic             flag_q;
    logic             phase_q;
    logic [CNT_W-1:0] cnt_q;

    // Set/reset flag: clear takes priority over a completing hit
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (clear) flag_q <= 1'b0;
        else if (hit)   flag_q <= 1'b1;
    end

    // Divider: runs while the flag is set, idle at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !flag_q) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == CNT_TOP) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    // Outputs: blink is forced low in the same cycle the flag is low
    always_comb begin
        found = flag_q;
        blink = flag_q & phase_q;
    end

endmodule

// File: rtl/trace_path_detector.sv
// Top of the pixel trace path detector. It decodes the sampled row, tracks
// the path through the frame and latches a detection with a blink output.
// Assumes: one sample pulse per scanned row, row_idx < N_ROWS on samples.
module trace_path_detector
    import trace_pkg::*;
#(
    parameter int N_ROWS     = 10,
    parameter int N_COLS     = 10,
    parameter int BLINK_HALF = 8,
    localparam int ROW_W = $clog2(N_ROWS),
    localparam int COL_W = $clog2(N_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  row_idx,
    input  logic              sample,
    input  logic [N_COLS-1:0] cols,
    input  logic [1:0]        mode,
    input  logic              clear,
    output logic              found,
    output logic              blink
);

    logic             one_hot;
    logic [COL_W-1:0] col_idx;
    logic             hit;
    trace_mode_e      mode_e;

    // Interpret the raw mode pins as the rule enumeration
    always_comb begin
        mode_e = trace_mode_e'(mode);
    end

    row_decoder #(.N_COLS(N_COLS)) u_dec (
        .cols    (cols),
        .one_hot (one_hot),
        .col_idx (col_idx)
    );

    path_tracker #(.N_ROWS(N_ROWS), .N_COLS(N_COLS)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .row_idx (row_idx),
        .mode    (mode_e),
        .one_hot (one_hot),
        .col_idx (col_idx),
        .hit     (hit)
    );

    flag_blinker #(.BLINK_HALF(BLINK_HALF)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clear (clear),
        .found (found),
        .blink (blink)
    );

endmodule

// File: rtl/trace_path_detector_chk.sv
// Property checker for the trace path detector, attached by bind.
// Assumes: the same parameter values as the instance it is bound to.
module trace_path_detector_chk #(
    parameter int N_ROWS = 10,
    parameter int N_COLS = 10,
    localparam int ROW_W = $clog2(N_ROWS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ROW_W-1:0]  row_idx,
    input logic              sample,
    input logic [N_COLS-1:0] cols,
    input logic              clear,
    input logic              found,
    input logic              blink
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_ROWS - 1);

    // R8: a rise of the flag follows a sample of the last row
    p_rise_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> ($past(sample) && ($past(row_idx) == LAST_ROW)));

    // R3: the completing row carried exactly one set bit
    p_rise_needs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> $past($onehot(cols)));

    // R2: no rise without a sample strobe
    p_no_rise_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> !$rose(found));

    // R9: the flag holds while clear is low
    p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !clear) |=> found);

    // R9: clear wins over everything at its edge
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !found);

    // R10: blink is gated by the flag
    p_blink_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> !blink);

endmodule

bind trace_path_detector trace_path_detector_chk #(
    .N_ROWS (N_ROWS),
    .N_COLS (N_COLS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_idx (row_idx),
    .sample  (sample),
    .cols    (cols),
    .clear   (clear),
    .found   (found),
    .blink   (blink)
);

// File: tb/test_trace_path_detector.sv
`timescale 1ns/1ps
module test_trace_path_detector;

    localparam int NR = 10;
    localparam int NC = 10;
    localparam int BH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    row_idx = '0;
    logic          sample = 1'b0;
    logic [NC-1:0] cols = '0;
    logic [1:0]    mode = '0;
    logic          clear = 1'b0;
    logic          found, blink;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [NC-1:0] frame [NR];

    always #2.5 clk = ~clk;

    trace_path_detector #(.N_ROWS(NR), .N_COLS(NC), .BLINK_HALF(BH)) i_trace_path_detector (
        .clk(clk), .rst_n(rst_n), .row_idx(row_idx), .sample(sample), .cols(cols),
        .mode(mode), .clear(clear), .found(found), .blink(blink)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int idx_of(logic [NC-1:0] v);
        for (int i = 0; i < NC; i++) if (v[i]) return i;
        return -1;
    endfunction

    // Expected verdict of a full frame, computed from the rules
    function automatic int model(int m);
        int prev = 0;
        int lean = 0;
        for (int r = 0; r < NR; r++) begin
            int c;
            if ($countones(frame[r]) != 1) return 0;
            c = idx_of(frame[r]);
            if (m == 0) begin
                if (c != r) return 0;
            end else if (r > 0) begin
                int d = c - prev;
                if (d > 1 || d < -1) return 0;
                if (m >= 2 && d != 0) begin
                    if (lean == 0) lean = d;
                    else if (lean != d) return 0;
                end
            end
            prev = c;
        end
        return 1;
    endfunction

    task automatic send_row(int r, logic [NC-1:0] v, bit clr);
        @(negedge clk);
        row_idx = 4'(r);
        cols = v;
        sample = 1'b1;
        clear = clr;
        @(negedge clk);
        sample = 1'b0;
        clear = 1'b0;
        cols = ~v;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic run_frame(int m, int exp, string req);
        do_clear();
        mode = 2'(m);
        for (int r = 0; r < NR - 1; r++) send_row(r, frame[r], 1'b0);
        check({req, " no flag before last row (R8)"}, int'(found), 0);
        send_row(NR - 1, frame[NR - 1], 1'b0);
        check(req, int'(found), exp);
    endtask

    task automatic build(int start, int p, int m);
        int c = start;
        for (int r = 0; r < NR; r++) begin
            if (r > 0) begin
                int off;
                case (p)
                    0: off = 0;
                    1: off = 1;
                    2: off = -1;
                    3: off = (r % 2 == 1) ? 1 : -1;
                    4: off = ((r * 3 + start) % 3) - 1;
                    default: off = (r % 4 == 1) ? 1 : ((r % 4 == 3) ? -1 : 0);
                endcase
                if (c + off >= 0 && c + off < NC) c = c + off;
            end
            frame[r] = NC'(1) << c;
        end
        if ((start + p + m) % 4 == 0) begin
            int k = (start + p) % NR;
            if (k % 2 == 1) frame[k] = frame[k] | (NC'(1) << ((idx_of(frame[k]) + 3) % NC));
            else frame[k] = '0;
        end
    endtask

    task automatic diag_frame();
        for (int r = 0; r < NR; r++) frame[r] = NC'(1) << r;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 found after reset", int'(found), 0);
        check("R1 blink after reset", int'(blink), 0);
        rst_n = 1'b1;

        // Sweep of rules R3, R4, R5, R6 over start columns and shapes
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < NC; s++)
                for (int p = 0; p < 6; p++) begin
                    build(s, p, m);
                    case (m)
                        0: run_frame(m, model(m), "R4 R3 diagonal sweep");
                        1: run_frame(m, model(m), "R5 R3 curve sweep");
                        default: run_frame(m, model(m), "R6 R3 no-zigzag sweep");
                    endcase
                end

        // R4: exact diagonal passes
        diag_frame();
        run_frame(0, 1, "R4 exact diagonal");

        // R6: zero offsets before the first turn keep direction open
        for (int r = 0; r < NR; r++) frame[r] = NC'(1) << ((r < 4) ? 5 : ((r < 7) ? 5 - (r - 3) : 2));
        run_frame(2, 1, "R6 straight then left");

        // R2: activity while sample is low is ignored
        diag_frame();
        do_clear();
        mode = 2'd0;
        for (int r = 0; r < 5; r++) send_row(r, frame[r], 1'b0);
        @(negedge clk);
        row_idx = 4'd0;
        cols = '1;
        repeat (3) @(negedge clk);
        for (int r = 5; r < NR; r++) send_row(r, frame[r], 1'b0);
        check("R2 idle row-0 data ignored", int'(found), 1);

        // R7: skipped row fails
        for (int r = 0; r < NR; r++) frame[r] = NC'(1) << 3;
        do_clear();
        mode = 2'd1;
        for (int r = 0; r < NR; r++) if (r != 5) send_row(r, frame[r], 1'b0);
        check("R7 skipped row", int'(found), 0);

        // R7: repeated row fails
        do_clear();
        for (int r = 0; r < NR; r++) begin
            send_row(r, frame[r], 1'b0);
            if (r == 4) send_row(r, frame[r], 1'b0);
        end
        check("R7 repeated row", int'(found), 0);

        // R7: row 0 restarts after a broken partial frame
        do_clear();
        send_row(0, frame[0], 1'b0);
        send_row(1, 10'b0000011000, 1'b0);
        send_row(2, frame[2], 1'b0);
        for (int r = 0; r < NR; r++) send_row(r, frame[r], 1'b0);
        check("R7 restart at row 0", int'(found), 1);

        // R8 and R10: exact rise cycle and blink timing
        do_clear();
        for (int r = 0; r < NR - 1; r++) send_row(r, frame[r], 1'b0);
        @(negedge clk);
        row_idx = 4'(NR - 1);
        cols = frame[NR - 1];
        sample = 1'b1;
        check("R8 flag low before completing edge", int'(found), 0);
        @(negedge clk);
        sample = 1'b0;
        check("R8 flag rises after last sample", int'(found), 1);
        check("R10 blink low at start", int'(blink), 0);
        repeat (BH - 1) @(negedge clk);
        check("R10 blink still low", int'(blink), 0);
        @(negedge clk);
        check("R10 blink high after half period", int'(blink), 1);
        repeat (BH) @(negedge clk);
        check("R10 blink low after full period", int'(blink), 0);
        repeat (BH) @(negedge clk);
        check("R10 blink high again", int'(blink), 1);

        // R9: sticky across a failing frame
        for (int r = 0; r < NR; r++) send_row(r, '0, 1'b0);
        check("R9 flag sticky", int'(found), 1);

        // R10 and R9: clear drops flag and blink together
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check("R9 cleared", int'(found), 0);
        check("R10 blink off when flag off", int'(blink), 0);

        // R9: clear beats a completing sample at the same edge
        for (int r = 0; r < NR; r++) send_row(r, frame[r], 1'b0);
        check("R9 set before priority test", int'(found), 1);
        for (int r = 0; r < NR - 1; r++) send_row(r, frame[r], 1'b0);
        send_row(NR - 1, frame[NR - 1], 1'b1);
        check("R9 clear wins over set", int'(found), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule